// File: doc/BRIEF.md
# Signed/Unsigned Magnitude Comparator

This block compares two operands of a parameterized width and drives six relation flags at once: equal, not equal, less, greater, less-or-equal and greater-or-equal. A single mode input chooses how both operands are read. When it is high they are unsigned binary; when it is low they are two's complement. There are no registers and no clock, so the flags settle as soon as the operands or the mode change.

Signed ordering is handled without a second comparator. The most significant bit of each operand is inverted, and the two biased values go through one unsigned compare. That compare is a balanced tree of per-bit cells. Each cell reports whether its bit pair is less, equal or greater. At every merge the more significant half wins unless it reports equal.

Top module: `mag_compare`

## Requirements
- R1: `is_eq` is high exactly when `opd_a` and `opd_b` are bit-identical. `is_ne` is its complement. Neither depends on `unsigned_mode`.
- R2: With `unsigned_mode` = 1, `is_lt` and `is_gt` follow the ordering of both operands read as unsigned binary numbers.
- R3: With `unsigned_mode` = 0, `is_lt` and `is_gt` follow the ordering of both operands read as two's-complement numbers, in which bit W-1 is the sign bit.
- R4: For every input combination, exactly one of `is_lt`, `is_eq` and `is_gt` is high.
- R5: `is_le` equals `is_lt` OR `is_eq`, and `is_ge` equals `is_gt` OR `is_eq`.
- R6: With `opd_a` = 100…0 and `opd_b` = 011…1, the block reports A greater than B when `unsigned_mode` = 1. It reports A less than B when `unsigned_mode` = 0.
- R7: At W = 1 with `unsigned_mode` = 0, an operand value of 1 is read as -1. So A = 1, B = 0 gives `is_lt` high.
- R8: The block is purely combinational. The flags reflect new inputs within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | W | First operand (A) |
| opd_b | input | W | Second operand (B) |
| unsigned_mode | input | 1 | 1: both operands unsigned; 0: both two's complement |
| is_eq | output | 1 | A equals B |
| is_ne | output | 1 | A differs from B |
| is_lt | output | 1 | A less than B |
| is_gt | output | 1 | A greater than B |
| is_le | output | 1 | A less than or equal to B |
| is_ge | output | 1 | A greater than or equal to B |

## Verification
The hardest situation to reach is the set of pairs whose order flips between the two modes. These are the pairs in which exactly one operand has its top bit set. Only there does the sign-bit inversion change the result.

At a width of four, every operand pair is driven in both modes, so each flipping pair is covered in both readings. The extreme 100…0 against 011…1 pair is also driven on its own. A second instance at width one covers the degenerate case, where the only bit is also the sign bit.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    // Relation of one operand slice against the other
    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } rel_t;

    // The six flags driven at the block edge
    typedef struct packed {
        logic eq;
        logic ne;
        logic lt;
        logic gt;
        logic le;
        logic ge;
    } flags_t;

    // Neutral element: a slice that is equal defers to the lower slice
    localparam rel_t REL_EQUAL = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};

    // Merge a more significant slice result with a less significant one
    function automatic rel_t rel_merge(input rel_t hi, input rel_t lo);
        rel_t r;
        r.lt = hi.lt | (hi.eq & lo.lt);
        r.gt = hi.gt | (hi.eq & lo.gt);
        r.eq = hi.eq & lo.eq;
        return r;
    endfunction

endpackage

// File: rtl/cmp_bias.sv
module cmp_bias #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         unsigned_mode,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o
);
    // Flipping the sign bit maps two's-complement order onto unsigned order
    logic [W-1:0] flip_d;

    always_comb begin
        flip_d        = '0;
        flip_d[W-1]   = ~unsigned_mode;
    end

    assign a_o = a_i ^ flip_d;
    assign b_o = b_i ^ flip_d;

endmodule

// File: rtl/cmp_tree.sv
module cmp_tree
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output rel_t         rel_o
);
    localparam int LEVELS = (W > 1) ? $clog2(W) : 0;
    localparam int P      = 1 << LEVELS;

    // Heap layout: node k has children 2k (lower) and 2k+1 (upper); leaves at P+i
    rel_t node [1:2*P-1];

    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < W) begin : g_bit
            assign node[P+i] = '{lt: ~a_i[i] &  b_i[i],
                                 eq: ~(a_i[i] ^ b_i[i]),
                                 gt:  a_i[i] & ~b_i[i]};
        end else begin : g_pad
            assign node[P+i] = REL_EQUAL;
        end
    end

    for (genvar k = 1; k < P; k++) begin : g_merge
        assign node[k] = rel_merge(node[2*k+1], node[2*k]);
    end

    assign rel_o = node[1];

endmodule

// File: rtl/cmp_flags.sv
module cmp_flags
    import cmp_pkg::*;
(
    input  rel_t   rel_i,
    output flags_t flags_o
);
    flags_t flags_d;

    always_comb begin
        flags_d.eq = rel_i.eq;
        flags_d.ne = ~rel_i.eq;
        flags_d.lt = rel_i.lt;
        flags_d.gt = rel_i.gt;
        flags_d.le = rel_i.lt | rel_i.eq;
        flags_d.ge = rel_i.gt | rel_i.eq;
    end

    assign flags_o = flags_d;

endmodule

// File: rtl/mag_compare.sv
module mag_compare
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opd_a,
    input  logic [W-1:0] opd_b,
    input  logic         unsigned_mode,
    output logic         is_eq,
    output logic         is_ne,
    output logic         is_lt,
    output logic         is_gt,
    output logic         is_le,
    output logic         is_ge
);
    logic [W-1:0] a_k;
    logic [W-1:0] b_k;
    rel_t         rel;
    flags_t       flags;

    cmp_bias #(.W(W)) u_bias (
        .a_i           (opd_a),
        .b_i           (opd_b),
        .unsigned_mode (unsigned_mode),
        .a_o           (a_k),
        .b_o           (b_k)
    );

    cmp_tree #(.W(W)) u_tree (
        .a_i   (a_k),
        .b_i   (b_k),
        .rel_o (rel)
    );

    cmp_flags u_flags (
        .rel_i   (rel),
        .flags_o (flags)
    );

    assign is_eq = flags.eq;
    assign is_ne = flags.ne;
    assign is_lt = flags.lt;
    assign is_gt = flags.gt;
    assign is_le = flags.le;
    assign is_ge = flags.ge;

    // Checks across the bias, tree and flag stages
    always_comb begin
        assert_eq_mode_free_R1: assert (is_eq == (opd_a == opd_b));
        assert_unsigned_order_R2: assert (!unsigned_mode || (is_lt == (opd_a < opd_b)));
        assert_signed_order_R3: assert (unsigned_mode || (is_lt == ($signed(opd_a) < $signed(opd_b))));
        assert_one_relation_R4: assert ($onehot({is_lt, is_eq, is_gt}));
        assert_derived_flags_R5: assert ((is_le == !is_gt) && (is_ge == !is_lt) && (is_ne == !is_eq));
    end

endmodule

// File: tb/mag_compare_test.sv
module mag_compare_test;

    localparam int W  = 4;
    localparam int N  = 1 << W;

    typedef struct {
        int         a;
        int         b;
        bit         mode;
        int         w;
        int         tag;   // requirement number covered by the ordering check
        logic [5:0] exp;   // {eq, ne, lt, gt, le, ge}
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic [W-1:0] a4, b4;
    logic         m4;
    logic         eq4, ne4, lt4, gt4, le4, ge4;
    logic [0:0]   a1, b1;
    logic         m1;
    logic         eq1, ne1, lt1, gt1, le1, ge1;

    mag_compare #(.W(W)) uut (
        .opd_a(a4), .opd_b(b4), .unsigned_mode(m4),
        .is_eq(eq4), .is_ne(ne4), .is_lt(lt4), .is_gt(gt4), .is_le(le4), .is_ge(ge4)
    );

    mag_compare #(.W(1)) uut_w1 (
        .opd_a(a1), .opd_b(b1), .unsigned_mode(m1),
        .is_eq(eq1), .is_ne(ne1), .is_lt(lt1), .is_gt(gt1), .is_le(le1), .is_ge(ge1)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    item_t sb [$];

    function automatic string tag_name(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic int to_value(int v, bit mode, int w);
        if (!mode && v >= (1 << (w - 1))) return v - (1 << w);
        return v;
    endfunction

    function automatic logic [5:0] model(int a, int b, bit mode, int w);
        int  va, vb;
        bit  e, l, g;
        va = to_value(a, mode, w);
        vb = to_value(b, mode, w);
        e  = (a == b);
        l  = (va < vb);
        g  = (va > vb);
        return {e, !e, l, g, l | e, g | e};
    endfunction

    task automatic check(bit ok, string req, logic [5:0] act, logic [5:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(int a, int b, bit mode, int w, int tag);
        item_t it;
        @(posedge clk);
        if (w == 1) begin
            a1 = a[0:0]; b1 = b[0:0]; m1 = mode;
        end else begin
            a4 = a[W-1:0]; b4 = b[W-1:0]; m4 = mode;
        end
        it.a = a; it.b = b; it.mode = mode; it.w = w; it.tag = tag;
        it.exp = model(a, b, mode, w);
        sb.push_back(it);
    endtask

    // Monitor: pops the scoreboard half a period after each drive
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t      it;
            logic [5:0] act;
            it  = sb.pop_front();
            act = (it.w == 1) ? {eq1, ne1, lt1, gt1, le1, ge1}
                              : {eq4, ne4, lt4, gt4, le4, ge4};
            check(act[5:4] == it.exp[5:4], "R1", act, it.exp);
            check(act[3:2] == it.exp[3:2], tag_name(it.tag), act, it.exp);
            check($onehot({act[3], act[5], act[2]}), "R4", act, it.exp);
            check((act[1] == (act[3] | act[5])) && (act[0] == (act[2] | act[5])),
                  "R5", act, it.exp);
        end
    end

    initial begin
        a4 = '0; b4 = '0; m4 = 1'b1;
        a1 = '0; b1 = '0; m1 = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: equal zero operands give eq, le, ge (R1)
        check({eq4, ne4, lt4, gt4, le4, ge4} == 6'b100011, "R1",
              {eq4, ne4, lt4, gt4, le4, ge4}, 6'b100011);
        rst = 1'b0;

        // Exhaustive sweep in both modes: R2 unsigned, R3 signed
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < N; a++)
                for (int b = 0; b < N; b++)
                    drive(a, b, m[0], W, (m == 1) ? 2 : 3);

        // R6: sign-boundary extreme in both modes
        drive(1 << (W - 1), (1 << (W - 1)) - 1, 1'b1, W, 6);
        drive(1 << (W - 1), (1 << (W - 1)) - 1, 1'b0, W, 6);

        // R7: width-one instance, all pairs and both modes
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 2; a++)
                for (int b = 0; b < 2; b++)
                    drive(a, b, m[0], 1, 7);

        @(posedge clk);
        @(negedge clk);

        // R8: outputs follow inputs without a clock edge
        #2;
        a4 = 4'd3; b4 = 4'd9; m4 = 1'b1;
        #1;
        check({lt4, gt4} == 2'b10, "R8", {eq4, ne4, lt4, gt4, le4, ge4}, model(3, 9, 1'b1, W));
        m4 = 1'b0;
        #1;
        check({lt4, gt4} == 2'b01, "R8", {eq4, ne4, lt4, gt4, le4, ge4}, model(3, 9, 1'b0, W));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8 watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule